// File: doc/BRIEF.md
# Circular-Buffer Address Mask

This block holds a 16-bit address mask next to a multiply-accumulate datapath and applies it to operand addresses. Software writes the mask over a 32-bit register bus and reads it back. When an operation asks for masking, the block ANDs the 32-bit effective address with a word made of all ones in the upper half and the stored mask in the lower half. The upper half of the address never changes.

Clearing mask bits forces the matching address bits to zero, so the masked address stays inside an aligned power-of-two window within the current 64 KiB page. A pointer that is post-incremented from the masked address therefore wraps back to the start of the window, which gives a circular queue with no compare or reload logic. Address generation and the memory access itself are done elsewhere. The masked address is combinational and adds no cycle of latency.

Top module: `cbuf_addr_mask`

## Requirements
- R1: After reset the stored mask is 16'hFFFF, so the readback is 32'hFFFF_FFFF and enabling masking leaves every address unchanged.
- R2: A write (write enable high at a rising clock edge) stores write data bits [15:0] as the mask. Write data bits [31:16] are discarded. The readback shows the new value from the cycle after that edge.
- R3: Readback bits [31:16] are always 16'hFFFF, whatever was written.
- R4: With the mask enable high, the output address equals the effective address ANDed with {16'hFFFF, mask}.
- R5: With the mask enable low, the output address equals the effective address, whatever the mask holds.
- R6: The output address follows the effective address and the mask enable in the same cycle, with no clock edge in between.
- R7: Output address bits [31:16] always equal effective address bits [31:16].
- R8: With mask 16'h000F and masking enabled, a pointer that starts at an address with bits [15:0] equal to zero and is reloaded each step with the masked address plus 4 visits offsets 0, 4, 8 and C and then wraps to 0.
- R9: While the write enable is low, clock edges leave the stored mask and the readback unchanged, whatever is on the write data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wdata | input | 32 | Register write data; only [15:0] is kept |
| cfg_rdata | output | 32 | Register readback: ones above, mask below |
| mask_on | input | 1 | Per-operation masking enable |
| eff_addr | input | 32 | Effective address from the address generator |
| op_addr | output | 32 | Final operand address |

## Verification
The bench writes each single-cleared-bit mask and a spread of multi-bit masks, with junk in the upper write-data half. A design that stored or echoed those upper bits would show them in the readback, and one that masked the upper address half would change op_addr[31:16] on the all-ones and walking-bit addresses. Every mask is tried with masking on and off, so a block that ignored the enable, or inverted it, gives wrong addresses at once. The address is checked one time unit after a change with no clock edge in between, which catches any added register stage. The circular-pointer walk shows that masked addresses wrap at the window boundary rather than carrying into the next window.

// File: rtl/cbuf_mask_pkg.sv
// Package: shared widths and helpers for the circular-buffer address mask.
// Assumes the mask covers the low half of the address; the upper half is
// always passed as ones.
package cbuf_mask_pkg;

    localparam int unsigned ADDR_W_DEF = 32;
    localparam int unsigned MASK_W_DEF = 16;

    // Mask value held after reset: every bit set, so masking is transparent.
    localparam logic [MASK_W_DEF-1:0] MASK_RESET = {MASK_W_DEF{1'b1}};

endpackage

// File: rtl/cbuf_mask_store.sv
// Module: cbuf_mask_store
// Holds the mask and forms the bus readback. Only the low MASK_W bits of
// the write data are kept; readback bits above MASK_W read as ones.
// Assumes BUS_W > MASK_W and a synchronous active-low reset.
module cbuf_mask_store #(
    parameter int unsigned BUS_W  = 32,
    parameter int unsigned MASK_W = 16,
    parameter logic [MASK_W-1:0] RST_VAL = {MASK_W{1'b1}}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BUS_W-1:0]  wdata,
    output logic [MASK_W-1:0] mask_q,
    output logic [BUS_W-1:0]  rdata
);

    localparam int unsigned HI_W = BUS_W - MASK_W;

    logic [HI_W-1:0] unused_wdata_hi;

    // Discarded upper write bits, kept named so they are visibly dropped.
    assign unused_wdata_hi = wdata[BUS_W-1:MASK_W];

    // Mask register: reset to transparent, load the low half on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= RST_VAL;
        end else if (wr_en) begin
            mask_q <= wdata[MASK_W-1:0];
        end
    end

    // Readback: forced ones above the stored field.
    always_comb begin
        rdata = {{HI_W{1'b1}}, mask_q};
    end

endmodule

// File: rtl/cbuf_addr_gate.sv
// Module: cbuf_addr_gate
// Purely combinational address gate. Each low address bit is cleared when
// masking is on and its mask bit is zero; upper bits always pass through.
// Assumes ADDR_W > MASK_W.
module cbuf_addr_gate #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned MASK_W = 16
) (
    input  logic              en,
    input  logic [MASK_W-1:0] mask,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);

    genvar gi;
    generate
        for (gi = 0; gi < ADDR_W; gi++) begin : g_bit
            if (gi < MASK_W) begin : g_lo
                // Low bit: gated by its mask bit when enabled.
                assign addr_out[gi] = addr_in[gi] & (mask[gi] | ~en);
            end else begin : g_hi
                // High bit: never masked.
                assign addr_out[gi] = addr_in[gi];
            end
        end
    endgenerate

endmodule

// File: rtl/cbuf_addr_mask.sv
// Module: cbuf_addr_mask (top)
// Address mask register with readback plus the combinational masking path
// for a multiply-accumulate unit's operand addresses. Assumes the caller
// generates the effective address and drives the per-operation enable.
module cbuf_addr_mask #(
    parameter int unsigned ADDR_W = cbuf_mask_pkg::ADDR_W_DEF,
    parameter int unsigned MASK_W = cbuf_mask_pkg::MASK_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] cfg_rdata,
    input  logic              mask_on,
    input  logic [ADDR_W-1:0] eff_addr,
    output logic [ADDR_W-1:0] op_addr
);

    logic [MASK_W-1:0] mask_q;

    cbuf_mask_store #(
        .BUS_W  (ADDR_W),
        .MASK_W (MASK_W),
        .RST_VAL({MASK_W{1'b1}})
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_wr_en),
        .wdata  (cfg_wdata),
        .mask_q (mask_q),
        .rdata  (cfg_rdata)
    );

    cbuf_addr_gate #(
        .ADDR_W (ADDR_W),
        .MASK_W (MASK_W)
    ) u_gate (
        .en       (mask_on),
        .mask     (mask_q),
        .addr_in  (eff_addr),
        .addr_out (op_addr)
    );

endmodule

// File: rtl/cbuf_addr_mask_chk.sv
// Module: cbuf_addr_mask_chk
// Port-level assertions for cbuf_addr_mask, attached with bind below.
// Assumes the same widths as the top it is bound to.
module cbuf_addr_mask_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned MASK_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr_en,
    input logic [ADDR_W-1:0] cfg_wdata,
    input logic [ADDR_W-1:0] cfg_rdata,
    input logic              mask_on,
    input logic [ADDR_W-1:0] eff_addr,
    input logic [ADDR_W-1:0] op_addr
);

    // R3: readback upper half is always ones
    a_r3_upper_ones: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[ADDR_W-1:MASK_W] == {(ADDR_W-MASK_W){1'b1}});

    // R2: a write shows its low half in the readback one cycle later
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_en |=> cfg_rdata[MASK_W-1:0] == $past(cfg_wdata[MASK_W-1:0]));

    // R9: no write, no change
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr_en |=> $stable(cfg_rdata));

    // R4: enabled output is address ANDed with readback
    a_r4_masked: assert property (@(posedge clk) disable iff (!rst_n)
        mask_on |-> op_addr == (eff_addr & cfg_rdata));

    // R5: disabled output passes through
    a_r5_pass: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_on |-> op_addr == eff_addr);

    // R7: upper address half is never altered
    a_r7_upper_addr: assert property (@(posedge clk) disable iff (!rst_n)
        op_addr[ADDR_W-1:MASK_W] == eff_addr[ADDR_W-1:MASK_W]);

endmodule

bind cbuf_addr_mask cbuf_addr_mask_chk #(
    .ADDR_W (ADDR_W),
    .MASK_W (MASK_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr_en (cfg_wr_en),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .mask_on   (mask_on),
    .eff_addr  (eff_addr),
    .op_addr   (op_addr)
);

// File: tb/cbuf_addr_mask_tb.sv
// Bench for cbuf_addr_mask: mask sweeps with arithmetic expected values.
module cbuf_addr_mask_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr_en;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        mask_on;
    logic [31:0] eff_addr;
    logic [31:0] op_addr;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    cbuf_addr_mask u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr_en (cfg_wr_en),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .mask_on   (mask_on),
        .eff_addr  (eff_addr),
        .op_addr   (op_addr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // Write one word; returns at the negedge after the capturing edge.
    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        cfg_wdata = ~d;
    endtask

    // Apply an address and enable, check combinationally (R4, R5, R6, R7).
    task automatic try_addr(input logic [15:0] m, input logic [31:0] a);
        mask_on  = 1'b1;
        eff_addr = a;
        #1;
        check("R4/R6", op_addr, a & {16'hFFFF, m});
        check("R7", {16'h0, op_addr[31:16]}, {16'h0, a[31:16]});
        mask_on = 1'b0;
        #1;
        check("R5", op_addr, a);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] ptr;
        logic [15:0] m;
        rst_n     = 1'b0;
        cfg_wr_en = 1'b0;
        cfg_wdata = 32'h0;
        mask_on   = 1'b0;
        eff_addr  = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset value and transparent masking
        check("R1", cfg_rdata, 32'hFFFF_FFFF);
        mask_on  = 1'b1;
        eff_addr = 32'h9ABC_DEF1;
        #1;
        check("R1", op_addr, 32'h9ABC_DEF1);

        // R2/R3: single cleared bit masks with junk above
        for (int k = 0; k < 16; k++) begin
            m = ~(16'h1 << k);
            wr({16'hA5A5 ^ 16'(k * 16'h0101), m});
            check("R2/R3", cfg_rdata, {16'hFFFF, m});
            try_addr(m, 32'hFFFF_FFFF);
            try_addr(m, 32'h1234_5678 ^ (32'h1 << k));
            try_addr(m, 32'h1 << (k + 16));
        end

        // Multi-bit mask patterns
        for (int j = 0; j < 16; j++) begin
            m = 16'(j * 16'h1111) ^ 16'h00FF;
            wr({16'h5A00 | 16'(j), m});
            check("R2/R3", cfg_rdata, {16'hFFFF, m});
            try_addr(m, 32'hDEAD_BEEF);
            try_addr(m, 32'(j) * 32'h0F0F_1357);
        end

        // R9: write enable low, data toggling, mask held
        wr(32'h0000_3C3C);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            cfg_wdata = 32'hFFFF_0000 | 32'(i);
        end
        @(negedge clk);
        check("R9", cfg_rdata, 32'hFFFF_3C3C);
        try_addr(16'h3C3C, 32'hFFFF_FFFF);

        // R6: address change with no clock edge in between
        @(negedge clk);
        mask_on  = 1'b1;
        eff_addr = 32'h0000_FFFF;
        #1;
        check("R6", op_addr, 32'h0000_3C3C);
        eff_addr = 32'h0001_0303;
        #1;
        check("R6", op_addr, 32'h0001_0000);

        // R8: circular walk through a 16-byte window
        wr(32'h0000_000F);
        mask_on = 1'b1;
        ptr = 32'h2001_0000;
        for (int s = 0; s < 10; s++) begin
            eff_addr = ptr;
            #1;
            check("R8", op_addr, 32'h2001_0000 | 32'((s % 4) * 4));
            ptr = op_addr + 32'd4;
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule